// File: doc/BRIEF.md
# Staged Serial Shutter Control Register

This block receives a 19-bit control word over a three-wire write-only port: a shift clock, a data line and a load strobe. All three wires arrive asynchronously and are brought into the system clock domain. Each rising edge of the shift clock moves one data bit into a shift register. A rising edge of the strobe copies the assembled word into the field registers.

The word holds three kinds of field. Four 2-bit phase selectors drive their outputs as soon as the strobe is seen, with no alignment to video timing. The 2-bit shutter mode and the 9-bit shutter speed are held back so that the exposure setting never changes in the middle of a frame. The mode is committed at the first line start that has the readout flag raised. The speed is committed at the next such line after that. A new strobe that arrives while an update is still in progress replaces the pending values, and the sequence starts again from the mode step.

Top module: `ccd_serial_ctrl`

## Requirements
- R1: Each of the three serial wires passes through a two-flop synchronizer. Each rising edge of the synchronized shift clock shifts in exactly one bit, however long the clock stays high.
- R2: The first bit shifted in is word bit 0, and after 19 shifts word bit i holds the i-th bit sent. If more than 19 bits are shifted before a strobe, only the last 19 are kept.
- R3: On a strobe rising edge, word bits 11..18 are copied to `phase_sel_o[7:0]` in the same order. Field k occupies bits [2k+1:2k], and its lower bit is the lower word bit.
- R4: `phase_sel_o` changes only on a strobe rising edge. Line starts and the readout flag have no effect on it.
- R5: Word bits 9..10 (bit 9 as LSB) reach `mode_o` on the first cycle after the strobe in which `line_start_i` and `readout_i` are both high. A line start with `readout_i` low commits nothing.
- R6: Word bits 0..8 (bit 0 as LSB) reach `speed_o` on the next qualifying line after the one that committed the mode, and never on that same line.
- R7: A strobe replaces any pending mode and speed values and restarts at the mode step. A qualifying line that falls on the same cycle as the strobe is not counted.
- R8: Once the speed has been committed, further qualifying lines leave `mode_o` and `speed_o` unchanged.
- R9: A synchronous active-low reset clears the synchronizers, the shift register and all output registers to zero.
- R10: Shift clock edges without a strobe do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_i | input | 1 | Asynchronous serial shift clock |
| sdat_i | input | 1 | Asynchronous serial data |
| sstb_i | input | 1 | Asynchronous load strobe |
| line_start_i | input | 1 | One-cycle pulse at each horizontal line start (clk domain) |
| readout_i | input | 1 | High during lines in which the readout pulse is active (clk domain) |
| speed_o | output | 9 | Committed shutter speed |
| mode_o | output | 2 | Committed shutter mode |
| phase_sel_o | output | 8 | Four 2-bit phase selectors, field k at [2k+1:2k] |

## Verification
The hardest case to reach is a qualifying line start that falls on exactly the same clock cycle as the internal strobe pulse. That pulse appears two clock cycles after the strobe pin rises, because of the synchronizer and the edge detector. The bench raises the strobe pin at a falling clock edge and waits two falling edges. It then raises the line start and readout together, so the line is seen on the cycle the word is captured. The bench then checks that the mode is committed only at the following qualifying line. The restart case is reached by strobing a second word between the mode commit and the speed commit of the first word.

// File: rtl/ccd_serial_ctrl_pkg.sv
// Package: shared types for the serial shutter control register.
// Assumes: nothing beyond IEEE 1800-2017.
package ccd_serial_ctrl_pkg;

    // Shutter commit sequence: idle, waiting for mode line, waiting for speed line.
    typedef enum logic [1:0] {
        STG_IDLE  = 2'd0,
        STG_MODE  = 2'd1,
        STG_SPEED = 2'd2
    } stage_e;

endpackage

// File: rtl/sync_bus.sv
// Module: sync_bus
// Brings WIDTH asynchronous wires into the clk domain through DEPTH flops each.
// Assumes: DEPTH >= 2; each wire is a level that stays stable for several clk cycles.
module sync_bus #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    // Shift the raw wires through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], async_i};
        end
    end

    assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/ser_shifter.sv
// Module: ser_shifter
// Serial-in shift register. A new bit enters at the top, so the first bit sent
// ends up in bit 0 once WORD_W bits have gone in.
// Assumes: shift_i is a one-cycle pulse in the clk domain.
module ser_shifter #(
    parameter int WORD_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word_q;

    // Move the word down one place and insert the new bit at the top on each shift pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_i) begin
            word_q <= {bit_i, word_q[WORD_W-1:1]};
        end
    end

    assign word_o = word_q;

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(word_q)); // R10

    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (word_q[WORD_W-2:0] == $past(word_q[WORD_W-1:1]))); // R2

endmodule

// File: rtl/phase_bank.sv
// Module: phase_bank
// PH_N phase-selector fields of PH_W bits each. All fields load together on load_i.
// Assumes: load_i is the one-cycle strobe pulse; no line alignment is applied.
module phase_bank #(
    parameter int PH_W = 2,
    parameter int PH_N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [PH_N*PH_W-1:0] word_i,
    output logic [PH_N*PH_W-1:0] phase_o
);

    localparam int PH_BITS = PH_N * PH_W;

    logic [PH_BITS-1:0] phase_q;

    genvar k;
    generate
        for (k = 0; k < PH_N; k++) begin : g_field
            // Load phase field k from its slice of the word on the strobe pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase_q[k*PH_W +: PH_W] <= '0;
                end else if (load_i) begin
                    phase_q[k*PH_W +: PH_W] <= word_i[k*PH_W +: PH_W];
                end
            end
        end
    endgenerate

    assign phase_o = phase_q;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(phase_q)); // R4

endmodule

// File: rtl/shutter_stager.sv
// Module: shutter_stager
// Holds the strobed shutter mode and speed, and commits them in two steps:
// the mode at the first qualifying line (line start with readout high), and
// the speed at the next qualifying line. A new load restarts the sequence.
// Assumes: line_start_i is a one-cycle pulse and readout_i a level, both in clk domain.
module shutter_stager
    import ccd_serial_ctrl_pkg::*;
#(
    parameter int SPEED_W = 9,
    parameter int MODE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [SPEED_W-1:0] speed_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               line_start_i,
    input  logic               readout_i,
    output logic [SPEED_W-1:0] speed_o,
    output logic [MODE_W-1:0]  mode_o
);

    stage_e             stage_q;
    logic [SPEED_W-1:0] pend_speed_q;
    logic [MODE_W-1:0]  pend_mode_q;
    logic [SPEED_W-1:0] speed_q;
    logic [MODE_W-1:0]  mode_q;
    logic               qual_line;

    assign qual_line = line_start_i & readout_i;

    // Capture the pending shutter values on every load; a load overwrites older ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_speed_q <= '0;
            pend_mode_q  <= '0;
        end else if (load_i) begin
            pend_speed_q <= speed_i;
            pend_mode_q  <= mode_i;
        end
    end

    // Step the commit sequence; a load has priority over a qualifying line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= STG_IDLE;
        end else if (load_i) begin
            stage_q <= STG_MODE;
        end else if (qual_line) begin
            case (stage_q)
                STG_MODE:  stage_q <= STG_SPEED;
                STG_SPEED: stage_q <= STG_IDLE;
                default:   stage_q <= STG_IDLE;
            endcase
        end
    end

    // Commit the mode on the first qualifying line of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (!load_i && qual_line && stage_q == STG_MODE) begin
            mode_q <= pend_mode_q;
        end
    end

    // Commit the speed on the qualifying line after the mode commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= '0;
        end else if (!load_i && qual_line && stage_q == STG_SPEED) begin
            speed_q <= pend_speed_q;
        end
    end

    assign speed_o = speed_q;
    assign mode_o  = mode_q;

    AST_MODE_ONLY_IN_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != STG_MODE) |=> $stable(mode_q)); // R5

    AST_MODE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_line |=> $stable(mode_q)); // R5

    AST_SPEED_ONLY_IN_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != STG_SPEED) |=> $stable(speed_q)); // R6

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (stage_q == STG_MODE)); // R7

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == STG_IDLE && !load_i) |=> (stage_q == STG_IDLE)); // R8

endmodule

// File: rtl/ccd_serial_ctrl.sv
// Module: ccd_serial_ctrl (top)
// Three-wire write-only control port. It synchronizes the wires, detects the
// rising edges of the shift clock and strobe, shifts the word in, and sends
// the fields to the phase bank (immediate) and the shutter stager (line-aligned).
// Assumes: serial data is stable around each shift clock rise, and every level
// on the serial wires is held for at least SYNC_DEPTH+1 clk cycles.
module ccd_serial_ctrl #(
    parameter int SPEED_W    = 9,
    parameter int MODE_W     = 2,
    parameter int PH_W       = 2,
    parameter int PH_N       = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 sdat_i,
    input  logic                 sstb_i,
    input  logic                 line_start_i,
    input  logic                 readout_i,
    output logic [SPEED_W-1:0]   speed_o,
    output logic [MODE_W-1:0]    mode_o,
    output logic [PH_N*PH_W-1:0] phase_sel_o
);

    localparam int PH_BITS  = PH_N * PH_W;
    localparam int WORD_W   = SPEED_W + MODE_W + PH_BITS;
    localparam int MODE_LSB = SPEED_W;
    localparam int PH_LSB   = SPEED_W + MODE_W;
    localparam int IDX_CLK  = 0;
    localparam int IDX_DAT  = 1;
    localparam int IDX_STB  = 2;

    logic [2:0]        raw_wires;
    logic [2:0]        sync_wires;
    logic              sclk_prev_q;
    logic              sstb_prev_q;
    logic              shift_pulse;
    logic              load_pulse;
    logic [WORD_W-1:0] word;

    assign raw_wires = {sstb_i, sdat_i, sclk_i};

    sync_bus #(
        .WIDTH (3),
        .DEPTH (SYNC_DEPTH)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_wires),
        .sync_o  (sync_wires)
    );

    // Remember the previous synchronized clock and strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            sstb_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sync_wires[IDX_CLK];
            sstb_prev_q <= sync_wires[IDX_STB];
        end
    end

    assign shift_pulse = sync_wires[IDX_CLK] & ~sclk_prev_q;
    assign load_pulse  = sync_wires[IDX_STB] & ~sstb_prev_q;

    ser_shifter #(
        .WORD_W (WORD_W)
    ) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_pulse),
        .bit_i   (sync_wires[IDX_DAT]),
        .word_o  (word)
    );

    phase_bank #(
        .PH_W (PH_W),
        .PH_N (PH_N)
    ) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_pulse),
        .word_i  (word[WORD_W-1:PH_LSB]),
        .phase_o (phase_sel_o)
    );

    shutter_stager #(
        .SPEED_W (SPEED_W),
        .MODE_W  (MODE_W)
    ) i_stager (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_pulse),
        .speed_i      (word[SPEED_W-1:0]),
        .mode_i       (word[PH_LSB-1:MODE_LSB]),
        .line_start_i (line_start_i),
        .readout_i    (readout_i),
        .speed_o      (speed_o),
        .mode_o       (mode_o)
    );

    AST_ONE_SHIFT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse); // R1

    AST_ONE_LOAD_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse); // R3

    AST_PHASE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (phase_sel_o == $past(word[WORD_W-1:PH_LSB]))); // R3

endmodule

// File: tb/test_ccd_serial_ctrl.sv
module test_ccd_serial_ctrl;

    localparam int SPEED_W = 9;
    localparam int MODE_W  = 2;
    localparam int PH_W    = 2;
    localparam int PH_N    = 4;
    localparam int WORD_W  = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic sstb = 1'b0;
    logic line_start = 1'b0;
    logic readout = 1'b0;
    logic [SPEED_W-1:0]   speed;
    logic [MODE_W-1:0]    mode;
    logic [PH_N*PH_W-1:0] phase;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] cur_sp = '0;
    logic [31:0] cur_md = '0;
    logic [31:0] cur_ph = '0;

    always #10 clk = ~clk;

    ccd_serial_ctrl i_ccd_serial_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .sdat_i       (sdat),
        .sstb_i       (sstb),
        .line_start_i (line_start),
        .readout_i    (readout),
        .speed_o      (speed),
        .mode_o       (mode),
        .phase_sel_o  (phase)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " speed"}, 32'(speed), cur_sp);
        check({req, " mode"},  32'(mode),  cur_md);
        check({req, " phase"}, 32'(phase), cur_ph);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        sdat = b;
        idle(3);
        sclk = 1'b1;
        idle(4);
        sclk = 1'b0;
        idle(4);
    endtask

    task automatic send(logic [31:0] w, int nbits);
        for (int i = 0; i < nbits; i++) shift_bit(w[i]);
    endtask

    task automatic strobe();
        sstb = 1'b1;
        idle(4);
        sstb = 1'b0;
        idle(4);
    endtask

    task automatic line(logic ro);
        line_start = 1'b1;
        readout = ro;
        idle(1);
        line_start = 1'b0;
        readout = 1'b0;
        idle(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] w;
        logic [31:0] w2;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        check_all("R9 reset state");

        // Sweep of words: immediate phases, two-stage shutter commit.
        for (int i = 0; i < 34; i++) begin
            if (i == 0)      w = 32'h7FFFF;
            else if (i == 1) w = 32'h0;
            else             w = (32'(i) * 32'd48271 + 32'd12345) & 32'h7FFFF;
            send(w, WORD_W);
            check_all("R10 shift without strobe");
            strobe();
            cur_ph = {24'd0, w[18:11]};
            check_all("R3 phase at strobe");
            line(1'b0);
            check_all("R5 line without readout");
            line(1'b1);
            cur_md = {30'd0, w[10:9]};
            check_all("R5 R6 mode step");
            line(1'b1);
            cur_sp = {23'd0, w[8:0]};
            check_all("R6 speed step");
            line(1'b1);
            check_all("R8 after commit");
            check_all("R4 phase unchanged by lines");
        end

        // Restart: a new strobe between mode and speed commit.
        w  = 32'h2A5C3;
        w2 = 32'h55A3C;
        send(w, WORD_W);
        strobe();
        cur_ph = {24'd0, w[18:11]};
        line(1'b1);
        cur_md = {30'd0, w[10:9]};
        check_all("R7 first mode");
        send(w2, WORD_W);
        strobe();
        cur_ph = {24'd0, w2[18:11]};
        check_all("R7 second strobe");
        line(1'b1);
        cur_md = {30'd0, w2[10:9]};
        check_all("R7 restart at mode");
        line(1'b1);
        cur_sp = {23'd0, w2[8:0]};
        check_all("R7 speed of new word");

        // Qualifying line on the same cycle as the internal strobe pulse.
        w = 32'h1C7E5;
        send(w, WORD_W);
        sstb = 1'b1;
        idle(2);
        line_start = 1'b1;
        readout = 1'b1;
        idle(1);
        line_start = 1'b0;
        readout = 1'b0;
        idle(2);
        sstb = 1'b0;
        idle(4);
        cur_ph = {24'd0, w[18:11]};
        check_all("R7 coincident line ignored");
        line(1'b1);
        cur_md = {30'd0, w[10:9]};
        check_all("R7 mode after coincident");
        line(1'b1);
        cur_sp = {23'd0, w[8:0]};
        check_all("R7 speed after coincident");

        // Over-long shift: only the last 19 bits are kept.
        w = 32'h5B3D29;
        send(w, 23);
        strobe();
        cur_ph = {24'd0, w[22:15]};
        check_all("R2 overshift phase");
        line(1'b1);
        cur_md = {30'd0, w[14:13]};
        line(1'b1);
        cur_sp = {23'd0, w[12:4]};
        check_all("R2 overshift shutter");

        // Long held shift clock high counts as one shift (R1).
        send(32'h3FFFE, WORD_W - 1);
        sdat = 1'b1;
        idle(3);
        sclk = 1'b1;
        idle(40);
        sclk = 1'b0;
        idle(4);
        strobe();
        cur_ph = 32'hFF;
        line(1'b1);
        cur_md = 32'h3;
        line(1'b1);
        cur_sp = 32'h1FE;
        check_all("R1 single shift per edge");

        // Reset clears outputs and the shift register.
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        cur_sp = '0;
        cur_md = '0;
        cur_ph = '0;
        check_all("R9 reset outputs");
        strobe();
        line(1'b1);
        line(1'b1);
        check_all("R9 shift register cleared");

        finish_run();
    end

endmodule